// File: doc/BRIEF.md
# Module clock enable sequencer

This block switches the functional clock of one peripheral module on or off by rewriting that module's clock-control register, then watches the module's idle-status field until the module confirms the new state. A caller raises a one-cycle request that says whether to enable or disable. With it come a mode code (hardware-supervised or software-supervised) and a flag that says whether to wait for status at all. The block also drives a level handshake towards the clock domain. It asks for the domain before it touches the module when enabling, and it gives the domain back only once the module has settled when disabling.

The control register is reached through a one-word read port and a one-word write port, each with valid/ready. The block reads the register once, builds the new word, writes it back, then reads it again once per cycle while it waits. The wait is bounded by a microsecond timeout, with one limit for enabling and a longer limit for disabling. The microsecond tick comes from a free-running prescaler.

Top module: `modclk_seq`

## Requirements
- R1: An enable with mode code 1 (hardware) or 2 (software) writes the last word read from the register with bits [1:0] replaced by the mode code and every other bit unchanged.
- R2: A disable with a nonzero mode code writes the last word read with bits [1:0] set to 0 and every other bit unchanged.
- R3: After an enable write, the block keeps reading while the idle-status field (bits [17:16]) reads 3, and it finishes once that field reads 0 (functional) or 2 (interface idle).
- R4: After a disable write, the block keeps reading while the idle-status field reads 0 or 2, and it finishes only once the field reads 3.
- R5: If an enable wait lasts EN_TMO_US microseconds (CYC_PER_US clock cycles each, so within one microsecond of EN_TMO_US*CYC_PER_US cycles), the block raises the error flag, finishes, and keeps the domain requested.
- R6: If a disable wait lasts DIS_TMO_US microseconds, the block raises the error flag and still releases the domain before finishing.
- R7: With the no-wait flag set, the block finishes right after the write and makes no read after the write.
- R8: With mode code 0, the block makes no register read or write. Enable still raises the domain request, and disable still drops it.
- R9: On enable, the domain request is raised and acknowledged before the register is written. On a waited disable, the domain request drops only after the module has reported idle-status 3.
- R10: The standby output follows bit 18 of the most recent word returned by a register read.
- R11: A request is taken only while busy is low. Busy is high from the cycle after a request is taken until the cycle after done, and done is a single-cycle pulse.
- R12: The error flag stays set until the next request is taken, which clears it. After reset, busy, done, error, standby, the domain request and both port valids are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | One-cycle request strobe, taken while busy is low |
| reqEnable | input | 1 | 1 = enable the module clock, 0 = disable |
| cfgMode | input | 2 | Mode code: 0 none, 1 hardware-supervised, 2 software-supervised |
| cfgNoWait | input | 1 | Skip the status wait after the write |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| tmoErr | output | 1 | Sticky timeout error |
| standby | output | 1 | Bit 18 of the last register word read |
| domReq | output | 1 | Clock domain request level |
| domAck | input | 1 | Clock domain acknowledge level |
| rdValid | output | 1 | Register read request |
| rdReady | input | 1 | Read data is returned this cycle |
| rdData | input | 32 | Register read data |
| wrValid | output | 1 | Register write request |
| wrReady | input | 1 | Write is taken this cycle |
| wrData | output | 32 | Register write data |

## Verification
The main sequence is tried with register words whose high bits are all ones, all zeros or mixed. Each word starts in a status code that the requested direction must not accept and changes after a delay. This separates a correct read-modify-write of bits [1:0] from one that corrupts other bits, and it shows whether the poll accepts both ready codes for enable but only code 3 for disable. No-wait and zero-mode patterns are told apart from the waited case by counting register accesses. Timeout runs with a status that never settles show which limit applies to each direction and whether the domain is kept or released.

// File: rtl/modclk_pkg.sv
package modclk_pkg;

  localparam int REG_W    = 32;
  localparam int MODE_LSB = 0;
  localparam int STS_LSB  = 16;
  localparam int STBY_BIT = 18;

  localparam logic [1:0] MODE_OFF  = 2'd0;
  localparam logic [1:0] STS_FUNC  = 2'd0;
  localparam logic [1:0] STS_IFIDL = 2'd2;
  localparam logic [1:0] STS_OFF   = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DOM_UP, ST_READ, ST_WRITE, ST_POLL, ST_DOM_DN, ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic       rdReq;
    logic       wrReq;
    logic       tmoClr;
    logic       tmoDis;
    logic [1:0] modeCode;
  } ctrl2dp_t;

  typedef struct packed {
    logic       rdFire;
    logic       wrFire;
    logic [1:0] idleSts;
    logic       tmoHit;
  } dp2ctrl_t;

endpackage

// File: rtl/modclk_dp.sv
module modclk_dp
  import modclk_pkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int EN_TMO_US  = 2000,
  parameter int DIS_TMO_US = 5000
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl2dp_t         strb,
  output dp2ctrl_t         dpSts,
  output logic             rdValid,
  input  logic             rdReady,
  input  logic [REG_W-1:0] rdData,
  output logic             wrValid,
  input  logic             wrReady,
  output logic [REG_W-1:0] wrData,
  output logic             standby
);

  localparam int PRE_W   = $clog2(CYC_PER_US + 1);
  localparam int LIM_MAX = (EN_TMO_US > DIS_TMO_US) ? EN_TMO_US : DIS_TMO_US;
  localparam int TMO_W   = $clog2(LIM_MAX + 1);

  logic [REG_W-1:0] shadowQ;
  logic             standbyQ;
  logic [PRE_W-1:0] preQ;
  logic             usTick;
  logic [TMO_W-1:0] tmoCntQ;
  logic [TMO_W-1:0] limSel;
  logic             rdFire;

  assign rdValid = strb.rdReq;
  assign wrValid = strb.wrReq;
  assign rdFire  = rdValid && rdReady;
  assign wrData  = {shadowQ[REG_W-1:MODE_LSB+2], strb.modeCode};
  assign standby = standbyQ;

  // read capture: shadow for the write, standby from every read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowQ  <= '0;
      standbyQ <= 1'b0;
    end else if (rdFire) begin
      shadowQ  <= rdData;
      standbyQ <= rdData[STBY_BIT];
    end
  end

  // free-running microsecond prescaler
  assign usTick = (preQ == PRE_W'(CYC_PER_US - 1));
  always_ff @(posedge clk) begin
    if (!rstN)       preQ <= '0;
    else if (usTick) preQ <= '0;
    else             preQ <= preQ + 1'b1;
  end

  // microsecond timeout counter, saturating at the selected limit
  assign limSel = strb.tmoDis ? TMO_W'(DIS_TMO_US) : TMO_W'(EN_TMO_US);
  always_ff @(posedge clk) begin
    if (!rstN)                           tmoCntQ <= '0;
    else if (strb.tmoClr)                tmoCntQ <= '0;
    else if (usTick && tmoCntQ < limSel) tmoCntQ <= tmoCntQ + 1'b1;
  end

  assign dpSts.rdFire  = rdFire;
  assign dpSts.wrFire  = wrValid && wrReady;
  assign dpSts.idleSts = rdData[STS_LSB +: 2];
  assign dpSts.tmoHit  = (tmoCntQ >= limSel);

  // R1
  wr_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrData[1:0] != 2'b11));

  // R5
  tmo_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    tmoCntQ <= TMO_W'(LIM_MAX));

  // R10
  stby_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |=> $stable(standby));

endmodule

// File: rtl/modclk_ctrl.sv
module modclk_ctrl
  import modclk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqEnable,
  input  logic [1:0] cfgMode,
  input  logic       cfgNoWait,
  input  logic       domAck,
  input  dp2ctrl_t   dpSts,
  output ctrl2dp_t   strb,
  output logic       domReq,
  output logic       busy,
  output logic       done,
  output logic       tmoErr
);

  seq_state_e stateQ, stateD;
  logic       enQ;
  logic [1:0] modeQ;
  logic       noWaitQ;
  logic       domReqQ;
  logic       errQ;
  logic       errSet;
  logic       reached;
  logic       take;
  seq_state_e finishSt;

  assign take     = (stateQ == ST_IDLE) && reqValid;
  assign finishSt = enQ ? ST_DONE : ST_DOM_DN;
  assign reached  = enQ ? (dpSts.idleSts == STS_FUNC || dpSts.idleSts == STS_IFIDL)
                        : (dpSts.idleSts == STS_OFF);

  always_comb begin
    stateD        = stateQ;
    errSet        = 1'b0;
    strb          = '0;
    strb.modeCode = enQ ? modeQ : MODE_OFF;
    strb.tmoDis   = !enQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          if (reqEnable)              stateD = ST_DOM_UP;
          else if (cfgMode == MODE_OFF) stateD = ST_DOM_DN;
          else                        stateD = ST_READ;
        end
      end
      ST_DOM_UP: begin
        if (domAck) stateD = (modeQ == MODE_OFF) ? ST_DONE : ST_READ;
      end
      ST_READ: begin
        strb.rdReq = 1'b1;
        if (dpSts.rdFire) stateD = ST_WRITE;
      end
      ST_WRITE: begin
        strb.wrReq  = 1'b1;
        strb.tmoClr = 1'b1;
        if (dpSts.wrFire) stateD = noWaitQ ? finishSt : ST_POLL;
      end
      ST_POLL: begin
        strb.rdReq = 1'b1;
        if (dpSts.rdFire && reached) begin
          stateD = finishSt;
        end else if (dpSts.tmoHit) begin
          errSet = 1'b1;
          stateD = finishSt;
        end
      end
      ST_DOM_DN: begin
        if (!domAck) stateD = ST_DONE;
      end
      ST_DONE:  stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      enQ     <= 1'b0;
      modeQ   <= MODE_OFF;
      noWaitQ <= 1'b0;
      domReqQ <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (take) begin
        enQ     <= reqEnable;
        modeQ   <= cfgMode;
        noWaitQ <= cfgNoWait;
      end
      if (take)        errQ <= 1'b0;
      else if (errSet) errQ <= 1'b1;
      if (stateD == ST_DOM_UP)      domReqQ <= 1'b1;
      else if (stateD == ST_DOM_DN) domReqQ <= 1'b0;
    end
  end

  assign domReq = domReqQ;
  assign busy   = (stateQ != ST_IDLE);
  assign done   = (stateQ == ST_DONE);
  assign tmoErr = errQ;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));

  // R9
  access_domain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrReq && enQ) |-> domAck);

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdReq && !dpSts.rdFire && !dpSts.tmoHit) |=> strb.rdReq);

endmodule

// File: rtl/modclk_seq.sv
module modclk_seq
  import modclk_pkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int EN_TMO_US  = 2000,
  parameter int DIS_TMO_US = 5000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqEnable,
  input  logic [1:0]  cfgMode,
  input  logic        cfgNoWait,
  output logic        busy,
  output logic        done,
  output logic        tmoErr,
  output logic        standby,
  output logic        domReq,
  input  logic        domAck,
  output logic        rdValid,
  input  logic        rdReady,
  input  logic [31:0] rdData,
  output logic        wrValid,
  input  logic        wrReady,
  output logic [31:0] wrData
);

  ctrl2dp_t strb;
  dp2ctrl_t dpSts;

  modclk_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqEnable (reqEnable),
    .cfgMode   (cfgMode),
    .cfgNoWait (cfgNoWait),
    .domAck    (domAck),
    .dpSts     (dpSts),
    .strb      (strb),
    .domReq    (domReq),
    .busy      (busy),
    .done      (done),
    .tmoErr    (tmoErr)
  );

  modclk_dp #(
    .CYC_PER_US (CYC_PER_US),
    .EN_TMO_US  (EN_TMO_US),
    .DIS_TMO_US (DIS_TMO_US)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .dpSts   (dpSts),
    .rdValid (rdValid),
    .rdReady (rdReady),
    .rdData  (rdData),
    .wrValid (wrValid),
    .wrReady (wrReady),
    .wrData  (wrData),
    .standby (standby)
  );

endmodule

// File: tb/modclk_seq_test.sv
module modclk_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int CYC_US     = 2;
  localparam int EN_US      = 2000;
  localparam int DIS_US     = 5000;
  localparam int WDOG       = 150000;

  // vector: en[69] mode[68:67] noWait[66] init[65:34] target[33:32] expWr[31:0]
  localparam int NV = 6;
  localparam logic [69:0] VECS [NV] = '{
    {1'b1, 2'd1, 1'b0, 32'h1237_00F0, 2'd0, 32'h1237_00F1},
    {1'b0, 2'd1, 1'b0, 32'h0000_0001, 2'd3, 32'h0000_0000},
    {1'b1, 2'd2, 1'b0, 32'hFFFF_FFFF, 2'd2, 32'hFFFF_FFFE},
    {1'b0, 2'd2, 1'b0, 32'h8002_0A02, 2'd3, 32'h8002_0A00},
    {1'b1, 2'd1, 1'b1, 32'h0003_0000, 2'd3, 32'h0003_0001},
    {1'b0, 2'd2, 1'b1, 32'h0000_5556, 2'd0, 32'h0000_5554}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqEnable = 1'b0, cfgNoWait = 1'b0;
  logic [1:0]  cfgMode = 2'd0;
  logic        busy, done, tmoErr, standby, domReq, domAck;
  logic        rdValid, wrValid;
  logic [31:0] rdData, wrData;

  // bench-side register and domain model
  logic [31:0] regModel;
  logic [1:0]  domPipe;
  logic        setupReq = 1'b0;
  logic [31:0] setupReg = '0;
  logic [1:0]  stsTgt = 2'd0;
  int          stsDelay = 5;
  int          stsCnt;
  int          rdCount, wrCount, rdAfterWr;
  logic        wrSeen, badOrder, curEn = 1'b0, domReqPrev;
  logic [1:0]  lastRdSts, stsAtRel;
  logic [31:0] lastWr;

  int checks = 0, errors = 0, cycles = 0;

  assign rdData = regModel;
  assign domAck = domPipe[1];

  modclk_seq #(.CYC_PER_US(CYC_US), .EN_TMO_US(EN_US), .DIS_TMO_US(DIS_US)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqEnable(reqEnable),
    .cfgMode(cfgMode), .cfgNoWait(cfgNoWait), .busy(busy), .done(done),
    .tmoErr(tmoErr), .standby(standby), .domReq(domReq), .domAck(domAck),
    .rdValid(rdValid), .rdReady(1'b1), .rdData(rdData), .wrValid(wrValid),
    .wrReady(1'b1), .wrData(wrData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      regModel <= '0; domPipe <= '0; stsCnt <= 0; rdCount <= 0; wrCount <= 0;
      rdAfterWr <= 0; wrSeen <= 0; badOrder <= 0; domReqPrev <= 0;
      lastRdSts <= 2'd1; stsAtRel <= 2'd1; lastWr <= '0;
    end else begin
      domPipe    <= {domPipe[0], domReq};
      domReqPrev <= domReq;
      if (domReqPrev && !domReq) stsAtRel <= lastRdSts;
      if (setupReq) begin
        regModel <= setupReg; stsCnt <= 0; rdCount <= 0; wrCount <= 0;
        rdAfterWr <= 0; wrSeen <= 0; lastRdSts <= 2'd1; stsAtRel <= 2'd1;
      end else begin
        if (rdValid) begin
          rdCount   <= rdCount + 1;
          lastRdSts <= regModel[17:16];
          if (wrSeen) rdAfterWr <= rdAfterWr + 1;
        end
        if (wrValid) begin
          wrCount  <= wrCount + 1;
          lastWr   <= wrData;
          wrSeen   <= 1'b1;
          if (curEn && !domAck) badOrder <= 1'b1;
          regModel <= {wrData[31:19], regModel[18:16], wrData[15:0]};
          stsCnt   <= stsDelay;
        end else if (stsCnt > 0) begin
          stsCnt <= stsCnt - 1;
          if (stsCnt == 1) regModel[17:16] <= stsTgt;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setup(input logic [31:0] init, input logic [1:0] tgt, input int dly);
    @(negedge clk);
    setupReg = init; stsTgt = tgt; stsDelay = dly; setupReq = 1'b1;
    @(negedge clk);
    setupReq = 1'b0;
  endtask

  task automatic runReq(input logic en, input logic [1:0] mode, input logic nw,
                        output int cyc);
    @(negedge clk);
    curEn = en; reqValid = 1'b1; reqEnable = en; cfgMode = mode; cfgNoWait = nw;
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 1;
    while (!done && cyc < 30000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, "R11 done seen", 32'(done), 32'd1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cycles, WDOG);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!busy && !done && !tmoErr, "R12 reset busy/done/err", {busy, done, tmoErr}, 0);
    chk(!standby && !domReq, "R12 reset standby/domReq", {standby, domReq}, 0);
    chk(!rdValid && !wrValid, "R12 reset valids", {rdValid, wrValid}, 0);

    // table-driven main sequences (R1 R2 R3 R4 R7 R9)
    for (int i = 0; i < NV; i++) begin
      logic [69:0] v;
      v = VECS[i];
      setup(v[65:34], v[33:32], 7);
      runReq(v[69], v[68:67], v[66], cyc);
      chk(lastWr == v[31:0], v[69] ? "R1 enable write word" : "R2 disable write word",
          lastWr, v[31:0]);
      chk(wrCount == 1, "R1 R2 single write", wrCount, 1);
      chk(!tmoErr, "R3 R4 no error", 32'(tmoErr), 0);
      if (v[66])
        chk(rdAfterWr == 0, "R7 no read after write", rdAfterWr, 0);
      else
        chk(rdAfterWr >= 2, v[69] ? "R3 polled until ready" : "R4 polled until idle",
            rdAfterWr, 2);
      chk(domReq == v[69], "R9 domain level at done", 32'(domReq), 32'(v[69]));
      if (!v[69] && !v[66])
        chk(stsAtRel == 2'd3, "R9 release after idle", stsAtRel, 3);
      @(negedge clk);
      chk(!done && !busy, "R11 done single pulse", {done, busy}, 0);
    end
    chk(!badOrder, "R9 domain acked before enable write", 32'(badOrder), 0);

    // R8 zero mode
    setup(32'h0003_0000, 2'd0, 3);
    runReq(1'b1, 2'd0, 1'b0, cyc);
    chk(rdCount == 0 && wrCount == 0, "R8 enable no access", rdCount + wrCount, 0);
    chk(domReq, "R8 enable raises domain", 32'(domReq), 1);
    runReq(1'b0, 2'd0, 1'b0, cyc);
    chk(rdCount == 0 && wrCount == 0, "R8 disable no access", rdCount + wrCount, 0);
    chk(!domReq, "R8 disable drops domain", 32'(domReq), 0);

    // R10 standby
    setup(32'h0007_0000, 2'd0, 3);
    runReq(1'b1, 2'd1, 1'b1, cyc);
    chk(standby, "R10 standby set", 32'(standby), 1);
    setup(32'h0003_0000, 2'd0, 3);
    runReq(1'b1, 2'd1, 1'b1, cyc);
    chk(!standby, "R10 standby clear", 32'(standby), 0);

    // R11 request ignored while busy
    setup(32'h0003_0000, 2'd0, 40);
    @(negedge clk);
    curEn = 1'b1; reqValid = 1'b1; reqEnable = 1'b1; cfgMode = 2'd2; cfgNoWait = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy, "R11 busy after take", 32'(busy), 1);
    @(negedge clk);
    reqValid = 1'b1; reqEnable = 1'b0; cfgMode = 2'd1;
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 0;
    while (!done && cyc < 30000) begin @(negedge clk); cyc++; end
    chk(wrCount == 1 && lastWr == 32'h0003_0002, "R11 busy request ignored", lastWr,
        32'h0003_0002);
    chk(domReq, "R11 ignored disable kept domain", 32'(domReq), 1);
    @(negedge clk);
    chk(!busy, "R11 not busy after done", 32'(busy), 0);

    // R5 enable timeout
    setup(32'h0003_0000, 2'd3, 1);
    runReq(1'b1, 2'd1, 1'b0, cyc);
    chk(tmoErr, "R5 enable timeout error", 32'(tmoErr), 1);
    chk(domReq, "R5 domain kept", 32'(domReq), 1);
    chk(cyc >= (EN_US - 1) * CYC_US && cyc <= (EN_US + 1) * CYC_US + 20,
        "R5 enable timeout length", cyc, EN_US * CYC_US);
    @(negedge clk);
    chk(tmoErr, "R12 error sticky", 32'(tmoErr), 1);

    // R6 disable timeout
    setup(32'h0000_0001, 2'd0, 1);
    runReq(1'b0, 2'd1, 1'b0, cyc);
    chk(tmoErr, "R6 disable timeout error", 32'(tmoErr), 1);
    chk(!domReq, "R6 domain released", 32'(domReq), 0);
    chk(cyc >= (DIS_US - 1) * CYC_US && cyc <= (DIS_US + 1) * CYC_US + 20,
        "R6 disable timeout length", cyc, DIS_US * CYC_US);

    // R12 error cleared by next request
    setup(32'h0003_0000, 2'd0, 3);
    runReq(1'b1, 2'd2, 1'b0, cyc);
    chk(!tmoErr, "R12 error cleared", 32'(tmoErr), 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule